// File: doc/BRIEF.md
# Sigma-Delta Fractional Feedback Ratio Controller

This block computes the integer ratio that the feedback counter of a fractional-N loop uses in each phase-comparison period. Software supplies an integer part and a 25-bit fraction. A third-order noise-shaping modulator advances once per comparison strobe. It uses three cascaded 25-bit accumulators whose carries are merged with first and second differences. The resulting small signed correction is added to the integer part and clamped to the legal range. Over many periods the delivered ratio averages to INT + FRAC/2^25.

Integer and fraction values become active only on a load strobe. By default a load also clears the modulator, so every new setting starts from the same state. A configuration input keeps the accumulated state across loads. A counter-hold input forces the divider logic to its load state: the output follows the integer part and the modulator is held clear. A prescaler-mode input selects the lowest legal integer value, and a flag reports any integer programmed below that minimum.

Top module: `frac_div_ctrl`

## Requirements
- R1: After reset, div_out is 23 and range_err is 0.
- R2: int_val and frac_val take effect only in a cycle where load_stb is 1. Changing them with load_stb at 0 leaves the output sequence unchanged.
- R3: On each cycle with cyc_stb=1, cnt_hold=0 and no clearing load, the three accumulators add the fraction, then the first stage's new sum, then the second stage's new sum, each modulo 2^25. The carries c1,c2,c3 give offset y = c1 + c2 − c2' + c3 − 2·c3' + c3'', where ' marks the carry from the previous step. div_out becomes clamp(INT + y) at that edge.
- R4: When cyc_stb and cnt_hold are 0, div_out does not change.
- R5: With FRAC = 0 after a modulator clear, every strobe yields exactly INT.
- R6: Over M strobes from a cleared modulator, the sum of (div_out − INT) is within 2 of floor(M·FRAC/2^25).
- R7: When no clamping applies, each step's div_out lies in [INT − 3, INT + 4].
- R8: A load with auto_clr_dis=0 clears all modulator state (accumulators and carry history). With auto_clr_dis=1, the state carries on across the load.
- R9: While cnt_hold=1, div_out equals clamp(INT), strobes do not advance the modulator, and the modulator restarts from a cleared state after release.
- R10: div_out is clamped to [floor, 4095], where floor is 23 when presc_hi=0 and 75 when presc_hi=1 (the mode sampled at the strobe).
- R11: One cycle after the active INT or presc_hi settles, range_err is 1 exactly when INT is below the floor for the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_val | input | 12 | Integer part to be loaded |
| frac_val | input | 25 | Fraction numerator (modulus 2^25) to be loaded |
| load_stb | input | 1 | Makes int_val/frac_val active; clears modulator unless disabled |
| auto_clr_dis | input | 1 | 1 keeps modulator state across loads |
| cyc_stb | input | 1 | One pulse per phase-comparison period |
| cnt_hold | input | 1 | Holds the divider logic in its load state |
| presc_hi | input | 1 | 1 selects the high prescaler mode (floor 75), 0 floor 23 |
| div_out | output | 12 | Ratio for the current comparison period |
| range_err | output | 1 | Active integer is below the mode floor |

## Verification
A corrupted accumulator or carry history does not show up as an out-of-range value. It shows up as a wrong ratio on the very next strobe, so the bench compares every strobe against an independent model of the modulator. A wrong history that then heals can still shift the long-run sum, which the average check over hundreds of strobes catches. A failure to clear on load, or under hold, makes the first post-load ratios differ from a fresh start within one to three strobes.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;
    localparam int FRAC_W  = 25;
    localparam int INT_W   = 12;
    localparam int OFS_W   = 4;
    localparam int N_STAGE = 3;
    localparam int FLOOR_LO = 23;
    localparam int FLOOR_HI = 75;
endpackage

// File: rtl/fdc_accum.sv
module fdc_accum #(
    parameter int W = 25
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         clr,
    input  logic [W-1:0] addend,
    output logic [W-1:0] sum_nx,
    output logic         carry
);
    typedef struct packed {
        logic [W-1:0] acc;
    } acc_st_t;

    acc_st_t    st_d, st_q;
    logic [W:0] total;

    always_comb begin
        total  = {1'b0, st_q.acc} + {1'b0, addend};
        carry  = total[W];
        sum_nx = total[W-1:0];
        st_d   = st_q;
        if (clr)
            st_d.acc = '0;
        else if (en)
            st_d.acc = total[W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fdc_noise_comb.sv
module fdc_noise_comb
    import frac_div_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    clr,
    input  logic [N_STAGE-1:0]      carries,
    output logic signed [OFS_W-1:0] ofs
);
    typedef struct packed {
        logic c2_p;
        logic c3_p;
        logic c3_pp;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        ofs = $signed(OFS_W'(carries[0]))
            + $signed(OFS_W'(carries[1])) - $signed(OFS_W'(hist_q.c2_p))
            + $signed(OFS_W'(carries[2])) - $signed(OFS_W'({hist_q.c3_p, 1'b0}))
            + $signed(OFS_W'(hist_q.c3_pp));
        hist_d = hist_q;
        if (clr) begin
            hist_d = '0;
        end else if (en) begin
            hist_d.c2_p  = carries[1];
            hist_d.c3_p  = carries[2];
            hist_d.c3_pp = hist_q.c3_p;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end
endmodule

// File: rtl/fdc_ratio_sat.sv
module fdc_ratio_sat
    import frac_div_pkg::*;
(
    input  logic [INT_W-1:0]        int_in,
    input  logic signed [OFS_W-1:0] ofs,
    input  logic                    presc_hi,
    output logic [INT_W-1:0]        ratio
);
    localparam int SW = INT_W + 2;
    localparam logic signed [SW-1:0] MAX_V = SW'((1 << INT_W) - 1);

    logic signed [SW-1:0] total;
    logic signed [SW-1:0] floor_v;

    always_comb begin
        floor_v = presc_hi ? SW'(FLOOR_HI) : SW'(FLOOR_LO);
        total   = $signed({2'b00, int_in}) + $signed({{(SW-OFS_W){ofs[OFS_W-1]}}, ofs});
        if (total < floor_v)
            ratio = floor_v[INT_W-1:0];
        else if (total > MAX_V)
            ratio = MAX_V[INT_W-1:0];
        else
            ratio = total[INT_W-1:0];
    end
endmodule

// File: rtl/frac_div_ctrl.sv
module frac_div_ctrl
    import frac_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INT_W-1:0]  int_val,
    input  logic [FRAC_W-1:0] frac_val,
    input  logic              load_stb,
    input  logic              auto_clr_dis,
    input  logic              cyc_stb,
    input  logic              cnt_hold,
    input  logic              presc_hi,
    output logic [INT_W-1:0]  div_out,
    output logic              range_err
);
    typedef struct packed {
        logic [INT_W-1:0]  act_int;
        logic [FRAC_W-1:0] act_frac;
        logic [INT_W-1:0]  div;
        logic              range_err;
    } ctl_t;

    ctl_t cur_d, cur_q;

    logic                    mod_clr;
    logic                    mod_en;
    logic [FRAC_W-1:0]       chain [0:N_STAGE];
    logic [N_STAGE-1:0]      carries;
    logic signed [OFS_W-1:0] ofs;
    logic [INT_W-1:0]        sat_int;
    logic signed [OFS_W-1:0] sat_ofs;
    logic [INT_W-1:0]        ratio;
    logic [INT_W-1:0]        act_int_w;

    assign mod_clr  = cnt_hold | (load_stb & ~auto_clr_dis);
    assign mod_en   = cyc_stb & ~mod_clr;
    assign chain[0] = cur_q.act_frac;

    for (genvar k = 0; k < N_STAGE; k++) begin : g_stage
        fdc_accum #(.W(FRAC_W)) u_acc (
            .clk    (clk),
            .rst_n  (rst_n),
            .en     (mod_en),
            .clr    (mod_clr),
            .addend (chain[k]),
            .sum_nx (chain[k+1]),
            .carry  (carries[k])
        );
    end

    fdc_noise_comb u_comb (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (mod_en),
        .clr     (mod_clr),
        .carries (carries),
        .ofs     (ofs)
    );

    fdc_ratio_sat u_sat (
        .int_in   (sat_int),
        .ofs      (sat_ofs),
        .presc_hi (presc_hi),
        .ratio    (ratio)
    );

    always_comb begin
        cur_d = cur_q;
        if (load_stb) begin
            cur_d.act_int  = int_val;
            cur_d.act_frac = frac_val;
        end
        sat_int = cnt_hold ? cur_d.act_int : cur_q.act_int;
        sat_ofs = cnt_hold ? '0 : ofs;
        if (cnt_hold || mod_en)
            cur_d.div = ratio;
        cur_d.range_err = presc_hi ? (cur_q.act_int < INT_W'(FLOOR_HI))
                                   : (cur_q.act_int < INT_W'(FLOOR_LO));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.act_int   <= INT_W'(FLOOR_LO);
            cur_q.act_frac  <= '0;
            cur_q.div       <= INT_W'(FLOOR_LO);
            cur_q.range_err <= 1'b0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign act_int_w = cur_q.act_int;
    assign div_out   = cur_q.div;
    assign range_err = cur_q.range_err;
endmodule

// File: rtl/fdc_checks.sv
module fdc_checks
    import frac_div_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_stb,
    input logic             load_stb,
    input logic             cnt_hold,
    input logic             presc_hi,
    input logic [INT_W-1:0] act_int,
    input logic [INT_W-1:0] div_out,
    input logic             range_err
);
    // R10
    div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_out >= INT_W'(FLOOR_LO));

    // R10
    mode_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && presc_hi && !cnt_hold && !load_stb) |=> div_out >= INT_W'(FLOOR_HI));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_stb && !cnt_hold) |=> $stable(div_out));

    // R9
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_hold && !load_stb && act_int >= INT_W'(FLOOR_HI)) |=> div_out == $past(act_int));

    // R11
    range_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_stb |=> range_err == ($past(act_int) < ($past(presc_hi) ? INT_W'(FLOOR_HI) : INT_W'(FLOOR_LO))));

    // R7
    step_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_stb && !cnt_hold && !load_stb && act_int >= INT_W'(FLOOR_HI + 3) && act_int <= INT_W'(4091))
        |=> (div_out >= $past(act_int) - INT_W'(3)) && (div_out <= $past(act_int) + INT_W'(4)));
endmodule

bind frac_div_ctrl fdc_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_stb   (cyc_stb),
    .load_stb  (load_stb),
    .cnt_hold  (cnt_hold),
    .presc_hi  (presc_hi),
    .act_int   (act_int_w),
    .div_out   (div_out),
    .range_err (range_err)
);

// File: tb/frac_div_ctrl_test.sv
module frac_div_ctrl_test;
    localparam longint MASK = (64'd1 << 25) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] int_val = 12'd0;
    logic [24:0] frac_val = 25'd0;
    logic        load_stb = 1'b0;
    logic        auto_clr_dis = 1'b0;
    logic        cyc_stb = 1'b0;
    logic        cnt_hold = 1'b0;
    logic        presc_hi = 1'b0;
    logic [11:0] div_out;
    logic        range_err;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    longint m_a1, m_a2, m_a3;
    longint m_p2, m_p3, m_pp3;
    longint m_int, m_frac;

    always #4 clk = ~clk;

    frac_div_ctrl uut (
        .clk(clk), .rst_n(rst_n), .int_val(int_val), .frac_val(frac_val),
        .load_stb(load_stb), .auto_clr_dis(auto_clr_dis), .cyc_stb(cyc_stb),
        .cnt_hold(cnt_hold), .presc_hi(presc_hi), .div_out(div_out), .range_err(range_err)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_a1 = 0; m_a2 = 0; m_a3 = 0; m_p2 = 0; m_p3 = 0; m_pp3 = 0;
    endtask

    task automatic model_step(output longint ratio, output longint y);
        longint c1, c2, c3, fl;
        m_a1 += m_frac; c1 = m_a1 >> 25; m_a1 &= MASK;
        m_a2 += m_a1;   c2 = m_a2 >> 25; m_a2 &= MASK;
        m_a3 += m_a2;   c3 = m_a3 >> 25; m_a3 &= MASK;
        y = c1 + c2 - m_p2 + c3 - 2 * m_p3 + m_pp3;
        m_pp3 = m_p3; m_p3 = c3; m_p2 = c2;
        fl = presc_hi ? 75 : 23;
        ratio = m_int + y;
        if (ratio < fl) ratio = fl;
        if (ratio > 4095) ratio = 4095;
    endtask

    // called at a falling edge
    task automatic do_load(input int iv, input int fv, input bit keep);
        int_val = 12'(iv); frac_val = 25'(fv); auto_clr_dis = keep; load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
        m_int = iv; m_frac = fv;
        if (!keep) model_clear();
    endtask

    // n strobes, each compared against the model
    task automatic run_exact(input int n, input string req, output longint ysum);
        longint r, y;
        ysum = 0;
        for (int i = 0; i < n; i++) begin
            cyc_stb = 1'b1;
            @(negedge clk);
            model_step(r, y);
            ysum += longint'(div_out) - m_int;
            chk(longint'(div_out) == r, req, div_out, r);
        end
        cyc_stb = 1'b0;
    endtask

    task automatic t_reset();
        chk(div_out == 12'd23, "R1", div_out, 23);
        chk(range_err == 1'b0, "R1", range_err, 0);
    endtask

    task automatic t_frac_zero();
        do_load(100, 0, 1'b0);
        for (int i = 0; i < 20; i++) begin
            cyc_stb = 1'b1;
            @(negedge clk);
            chk(div_out == 12'd100, "R5", div_out, 100);
        end
        cyc_stb = 1'b0;
    endtask

    task automatic t_exact();
        longint s, r, y;
        bit span_ok;
        do_load(1000, 25'h0A5A5A5, 1'b0);
        run_exact(150, "R3", s);
        span_ok = 1'b1;
        for (int i = 0; i < 100; i++) begin
            cyc_stb = 1'b1;
            @(negedge clk);
            model_step(r, y);
            if (div_out < 12'd997 || div_out > 12'd1004) span_ok = 1'b0;
        end
        cyc_stb = 1'b0;
        chk(span_ok, "R7", div_out, 1000);
    endtask

    task automatic t_average(input int fv, input int m);
        longint s, expv, d;
        do_load(1000, fv, 1'b0);
        run_exact(m, "R3", s);
        expv = (longint'(m) * fv) >> 25;
        d = s - expv;
        chk(d >= -2 && d <= 2, "R6", s, expv);
    endtask

    task automatic t_idle();
        logic [11:0] held;
        held = div_out;
        repeat (6) @(negedge clk);
        chk(div_out == held, "R4", div_out, held);
    endtask

    task automatic t_noload();
        longint s;
        frac_val = 25'h1FFFFFF; int_val = 12'd3000;
        run_exact(40, "R2", s);
    endtask

    task automatic t_autoclr();
        longint s;
        do_load(1000, 25'h0A5A5A5, 1'b0);
        run_exact(7, "R8", s);
        do_load(1000, 25'h0A5A5A5, 1'b0);
        run_exact(20, "R8", s);
        do_load(1200, 25'h1234567, 1'b1);
        run_exact(30, "R8", s);
        auto_clr_dis = 1'b0;
    endtask

    task automatic t_hold();
        longint s;
        do_load(2000, 25'h1555555, 1'b0);
        run_exact(5, "R3", s);
        cnt_hold = 1'b1;
        for (int i = 0; i < 6; i++) begin
            cyc_stb = 1'(i % 2);
            @(negedge clk);
            chk(div_out == 12'd2000, "R9", div_out, 2000);
        end
        cnt_hold = 1'b0; cyc_stb = 1'b0;
        model_clear();
        run_exact(20, "R9", s);
    endtask

    task automatic t_clamp();
        longint s;
        do_load(4095, 25'h1555555, 1'b0);
        run_exact(60, "R10", s);
        do_load(23, 25'h1ABCDEF, 1'b0);
        run_exact(60, "R10", s);
        presc_hi = 1'b1;
        do_load(50, 25'h0FFFFFF, 1'b0);
        for (int i = 0; i < 10; i++) begin
            cyc_stb = 1'b1;
            @(negedge clk);
            chk(div_out == 12'd75, "R10", div_out, 75);
        end
        cyc_stb = 1'b0;
    endtask

    task automatic t_range();
        // presc_hi=1 and INT=50 from previous test
        chk(range_err == 1'b1, "R11", range_err, 1);
        presc_hi = 1'b0;
        @(negedge clk);
        chk(range_err == 1'b0, "R11", range_err, 0);
        do_load(20, 0, 1'b0);
        @(negedge clk);
        chk(range_err == 1'b1, "R11", range_err, 1);
        presc_hi = 1'b1;
        do_load(75, 0, 1'b0);
        @(negedge clk);
        chk(range_err == 1'b0, "R11", range_err, 0);
        do_load(74, 0, 1'b0);
        @(negedge clk);
        chk(range_err == 1'b1, "R11", range_err, 1);
        presc_hi = 1'b0;
    endtask

    initial begin
        model_clear();
        m_int = 23; m_frac = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_frac_zero();
        t_exact();
        t_average(25'h1000000, 64);
        t_average(25'h1FFFFFF, 400);
        t_average(25'h0000123, 300);
        t_idle();
        t_noload();
        t_autoclr();
        t_hold();
        t_clamp();
        t_range();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_err++; n_chk++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule